// File: doc/BRIEF.md
# Dual-Clock FIFO with Read Rewind

This block moves data words from one clock domain to another through a small
circular store. The producer side runs on its own clock, with a clock enable and a
push strobe. The consumer side runs on a second, unrelated clock, with its own
clock enable and a pop strobe. Each side sees occupancy flags registered in its own
domain. The producer sees a full flag and an early-warning high-water flag. The
consumer sees an empty flag and a low-water flag. The full point and both warning
levels are elaboration parameters.

Positions cross between the domains as Gray-coded values one bit wider than the
address, through a chain of synchronising flops. A single synchronous global reset,
seen by both clocks, clears everything. A second reset acts on the consumer side
only. It moves the consumer position back to its origin and leaves the producer
position where it is, so everything written since the last global reset can be
popped a second time. This supports replaying a block of data after a transfer
error on the far side.

Top module: `dcfifo_retx`

## Requirements
- R1: While `rst` is high at a clock edge, that domain's position and flags return to their origin. `empty` and `low_wm` read 1. `full` and `high_wm` read 0. `rdata` reads 0.
- R2: A push is accepted when `wce`, `we` are both 1 and `full` is 0. The word is stored at the next slot, and `full`/`high_wm` on that same `wclk` edge reflect the new fill level.
- R3: `full` is 1 exactly when the producer-side fill level is at least `FULL_LVL` (a value from 1 to 2^AW−1). A push attempted while `full` is 1 changes neither the stored contents nor the fill level.
- R4: `high_wm` is 1 exactly when the producer-side fill level is at least `AF_LVL` (a value from 1 to FULL_LVL−1).
- R5: A pop is accepted when `rce`, `re` are both 1, `empty` is 0 and `rprst` is 0. `rdata` then takes the oldest unread word on that `rclk` edge, so words leave in the order they were pushed.
- R6: `empty` is 1 exactly when the consumer-side fill level is 0. A pop attempted while `empty` is 1 leaves `rdata` and the fill level unchanged.
- R7: `low_wm` is 1 exactly when the consumer-side fill level is at most `AE_LVL` (a value from 1 to FULL_LVL−1).
- R8: A push becomes visible in the consumer flags within three `rclk` edges. A pop frees space in the producer flags within three `wclk` edges.
- R9: An `rclk` edge with `rprst` high puts the consumer position back to its origin. This overrides any pop in that cycle, and `empty`/`low_wm` are recomputed on that same edge. The producer position is untouched, so later pops replay the words from the first one pushed after global reset, and words pushed afterwards follow them in order.
- R10: With `wce` low a push strobe has no effect. With `rce` low a pop strobe has no effect, and `rdata` holds.
- R11: Flags and data order stay correct after the positions wrap past 2^(AW+1) transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Producer clock |
| rst | input | 1 | Global synchronous reset, active high, held over edges of both clocks |
| wce | input | 1 | Producer clock enable |
| we | input | 1 | Push strobe |
| wdata | input | DW | Word to push |
| full | output | 1 | Fill level at or above FULL_LVL (producer domain) |
| high_wm | output | 1 | Fill level at or above AF_LVL (producer domain) |
| rclk | input | 1 | Consumer clock |
| rprst | input | 1 | Consumer-side rewind, synchronous to rclk |
| rce | input | 1 | Consumer clock enable |
| re | input | 1 | Pop strobe |
| rdata | output | DW | Last popped word, registered |
| empty | output | 1 | Fill level zero (consumer domain) |
| low_wm | output | 1 | Fill level at or below AE_LVL (consumer domain) |

## Verification
`full`, `high_wm`, `rdata`, `empty` and `low_wm` all change on the one edge of their own clock that accepts the push, pop or rewind. The bench applies each stimulus for exactly one cycle, from a falling edge to the next falling edge, and samples at that second falling edge. Flags in the opposite domain may lag by up to three destination edges. Before any such check, and before any same-domain check whose expected value relies on the opposite position, the bench waits four edges of each clock. Expected levels come from push and pop counters kept in the bench.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    typedef struct packed {
        logic full;
        logic high_wm;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic low_wm;
    } rd_flags_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_gray_sync.sv
module dcfifo_gray_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
    import dcfifo_pkg::*;
#(
    parameter int AW       = 4,
    parameter int FULL_LVL = 15,
    parameter int AF_LVL   = 12
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wce,
    input  logic          we,
    input  logic [AW:0]   rgray_sync,
    output logic          push_ok,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wgray,
    output wr_flags_t     flags
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_L = PW'(FULL_LVL);
    localparam logic [PW-1:0] AF_L   = PW'(AF_LVL);

    logic [PW-1:0] wptr_q, wptr_d, rptr_seen, level_d;
    logic [PW-1:0] wgray_q;
    wr_flags_t     flags_q;

    assign push_ok   = wce && we && !flags_q.full;
    assign wptr_d    = wptr_q + PW'(push_ok);
    assign rptr_seen = PW'(gray_to_bin(32'(rgray_sync)));
    assign level_d   = wptr_d - rptr_seen;

    always_ff @(posedge wclk) begin
        if (rst) begin
            wptr_q  <= '0;
            wgray_q <= '0;
            flags_q <= '{full: 1'b0, high_wm: 1'b0};
        end else begin
            wptr_q          <= wptr_d;
            wgray_q         <= PW'(bin_to_gray(32'(wptr_d)));
            flags_q.full    <= (level_d >= FULL_L);
            flags_q.high_wm <= (level_d >= AF_L);
        end
    end

    assign wptr  = wptr_q;
    assign wgray = wgray_q;
    assign flags = flags_q;
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
    import dcfifo_pkg::*;
#(
    parameter int AW     = 4,
    parameter int AE_LVL = 3
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          rprst,
    input  logic          rce,
    input  logic          re,
    input  logic [AW:0]   wgray_sync,
    output logic          pop_ok,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rgray,
    output rd_flags_t     flags
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] AE_L = PW'(AE_LVL);

    logic [PW-1:0] rptr_q, rptr_d, wptr_seen, level_d;
    logic [PW-1:0] rgray_q;
    rd_flags_t     flags_q;

    assign pop_ok    = rce && re && !flags_q.empty && !rprst;
    assign wptr_seen = PW'(gray_to_bin(32'(wgray_sync)));
    assign level_d   = wptr_seen - rptr_d;

    always_comb begin
        if (rprst) rptr_d = '0;
        else       rptr_d = rptr_q + PW'(pop_ok);
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rptr_q  <= '0;
            rgray_q <= '0;
            flags_q <= '{empty: 1'b1, low_wm: 1'b1};
        end else begin
            rptr_q         <= rptr_d;
            rgray_q        <= PW'(bin_to_gray(32'(rptr_d)));
            flags_q.empty  <= (level_d == '0);
            flags_q.low_wm <= (level_d <= AE_L);
        end
    end

    assign rptr  = rptr_q;
    assign rgray = rgray_q;
    assign flags = flags_q;
endmodule

// File: rtl/dcfifo_store.sv
module dcfifo_store #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst,
    input  logic          ren,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (wen) cells[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rst)      rdata_q <= '0;
        else if (ren) rdata_q <= cells[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dcfifo_retx.sv
module dcfifo_retx
    import dcfifo_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 4,
    parameter int FULL_LVL    = (1 << AW) - 1,
    parameter int AF_LVL      = FULL_LVL - 3,
    parameter int AE_LVL      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wce,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic          full,
    output logic          high_wm,
    input  logic          rclk,
    input  logic          rprst,
    input  logic          rce,
    input  logic          re,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          low_wm
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr_w, wgray_w, rgray_at_w;
    logic [PW-1:0] rptr_r, rgray_r, wgray_at_r;
    logic          push_ok, pop_ok;
    wr_flags_t     wflags;
    rd_flags_t     rflags;

    dcfifo_wr_side #(.AW(AW), .FULL_LVL(FULL_LVL), .AF_LVL(AF_LVL)) u_wr (
        .wclk(wclk), .rst(rst), .wce(wce), .we(we),
        .rgray_sync(rgray_at_w), .push_ok(push_ok),
        .wptr(wptr_w), .wgray(wgray_w), .flags(wflags)
    );

    dcfifo_rd_side #(.AW(AW), .AE_LVL(AE_LVL)) u_rd (
        .rclk(rclk), .rst(rst), .rprst(rprst), .rce(rce), .re(re),
        .wgray_sync(wgray_at_r), .pop_ok(pop_ok),
        .rptr(rptr_r), .rgray(rgray_r), .flags(rflags)
    );

    dcfifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst(rst), .d(wgray_w), .q(wgray_at_r)
    );

    dcfifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst(rst), .d(rgray_r), .q(rgray_at_w)
    );

    dcfifo_store #(.DW(DW), .AW(AW)) u_store (
        .wclk(wclk), .wen(push_ok), .waddr(wptr_w[AW-1:0]), .wdata(wdata),
        .rclk(rclk), .rst(rst), .ren(pop_ok), .raddr(rptr_r[AW-1:0]),
        .rdata(rdata)
    );

    assign full    = wflags.full;
    assign high_wm = wflags.high_wm;
    assign empty   = rflags.empty;
    assign low_wm  = rflags.low_wm;
endmodule

// File: rtl/dcfifo_retx_chk.sv
module dcfifo_retx_chk #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          rprst,
    input logic          wce,
    input logic          we,
    input logic          rce,
    input logic          re,
    input logic          full,
    input logic          high_wm,
    input logic          empty,
    input logic          low_wm,
    input logic [DW-1:0] rdata,
    input logic [AW:0]   wptr,
    input logic [AW:0]   rptr
);
    a_r2_push_advances: assert property (@(posedge wclk) disable iff (rst)
        (wce && we && !full) |=> (wptr == $past(wptr) + 1'b1));

    a_r3_no_push_when_full: assert property (@(posedge wclk) disable iff (rst)
        (wce && we && full) |=> (wptr == $past(wptr)));

    a_r4_full_implies_high: assert property (@(posedge wclk) disable iff (rst)
        full |-> high_wm);

    a_r10_wr_gated: assert property (@(posedge wclk) disable iff (rst)
        !(wce && we) |=> $stable(wptr));

    a_r5_pop_advances: assert property (@(posedge rclk) disable iff (rst)
        (rce && re && !empty && !rprst) |=> (rptr == $past(rptr) + 1'b1));

    a_r6_no_pop_when_empty: assert property (@(posedge rclk) disable iff (rst)
        (rce && re && empty && !rprst) |=> ($stable(rdata) && $stable(rptr)));

    a_r7_empty_implies_low: assert property (@(posedge rclk) disable iff (rst)
        empty |-> low_wm);

    a_r9_rewind_origin: assert property (@(posedge rclk) disable iff (rst)
        rprst |=> (rptr == '0));

    a_r10_rd_gated: assert property (@(posedge rclk) disable iff (rst)
        (!rce && !rprst) |=> ($stable(rdata) && $stable(rptr)));
endmodule

bind dcfifo_retx dcfifo_retx_chk #(.DW(DW), .AW(AW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .rprst(rprst),
    .wce(wce), .we(we), .rce(rce), .re(re),
    .full(full), .high_wm(high_wm), .empty(empty), .low_wm(low_wm),
    .rdata(rdata), .wptr(wptr_w), .rptr(rptr_r)
);

// File: tb/dcfifo_retx_test.sv
module dcfifo_retx_test;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int DW = 8, AW = 4, FULL_LVL = 15, AF_LVL = 12, AE_LVL = 3;

    logic wclk = 0, rclk = 0;
    logic rst = 1, wce = 0, we = 0, rprst = 0, rce = 0, re = 0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic full, high_wm, empty, low_wm;

    int checks = 0, errors = 0;
    int wr_cnt = 0, rd_idx = 0;
    logic [DW-1:0] hist [64];
    logic [DW-1:0] last_rd = '0;

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(RD_PERIOD/2)  rclk = ~rclk;

    dcfifo_retx #(.DW(DW), .AW(AW), .FULL_LVL(FULL_LVL), .AF_LVL(AF_LVL),
                  .AE_LVL(AE_LVL)) uut (
        .wclk(wclk), .rst(rst), .wce(wce), .we(we), .wdata(wdata),
        .full(full), .high_wm(high_wm),
        .rclk(rclk), .rprst(rprst), .rce(rce), .re(re), .rdata(rdata),
        .empty(empty), .low_wm(low_wm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int level();
        return wr_cnt - rd_idx;
    endfunction

    task automatic settle();
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    task automatic wr_flags_chk(input string req);
        chk({req, " full"},    32'(full),    32'(level() >= FULL_LVL));
        chk({req, " high_wm"}, 32'(high_wm), 32'(level() >= AF_LVL));
    endtask

    task automatic rd_flags_chk(input string req);
        chk({req, " empty"},  32'(empty),  32'(level() == 0));
        chk({req, " low_wm"}, 32'(low_wm), 32'(level() <= AE_LVL));
    endtask

    task automatic global_reset();
        @(negedge wclk) rst = 1;
        repeat (4) @(posedge rclk);
        repeat (2) @(posedge wclk);
        @(negedge wclk) rst = 0;
        wr_cnt = 0; rd_idx = 0; last_rd = '0;
        settle();
    endtask

    // push with clock enable en; checks producer flags on the accepting edge (R2, R3, R4)
    task automatic push(input logic [DW-1:0] d, input logic en);
        @(negedge wclk);
        wce = en; we = 1; wdata = d;
        @(negedge wclk);
        wce = 0; we = 0;
        if (en && level() < FULL_LVL) begin
            hist[wr_cnt] = d;
            wr_cnt++;
        end
        wr_flags_chk("R2 R3 R4 push");
    endtask

    // pop with clock enable en; checks data and consumer flags (R5, R6, R7, R10)
    task automatic pop(input logic en);
        @(negedge rclk);
        rce = en; re = 1;
        @(negedge rclk);
        rce = 0; re = 0;
        if (en && level() > 0) begin
            last_rd = hist[rd_idx];
            rd_idx++;
        end
        chk("R5 R6 R10 rdata", 32'(rdata), 32'(last_rd));
        rd_flags_chk("R6 R7 pop");
    endtask

    initial begin
        global_reset();
        // R1 reset state
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 low_wm", 32'(low_wm), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 high_wm", 32'(high_wm), 32'd0);
        chk("R1 rdata", 32'(rdata), 32'd0);

        // R6 pop while empty is ignored
        pop(1'b1);
        // R10 push with wce low is ignored
        push(8'h5A, 1'b0);
        settle();
        rd_flags_chk("R10 after gated push");

        // fill sweep through every level, one push past full (R3, R8)
        for (int i = 0; i <= FULL_LVL; i++) begin
            push(8'(8'hA0 + i), 1'b1);
            settle();
            rd_flags_chk("R8 fill");
        end
        // drain sweep, one pop past empty (R5, R6, R8)
        for (int i = 0; i <= FULL_LVL; i++) begin
            pop(1'b1);
            settle();
            wr_flags_chk("R8 drain");
        end

        // R11 wrap sweep, with a gated pop (R10)
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 12; k++) push(8'(r * 16 + k * 7 + 3), 1'b1);
            settle();
            rd_flags_chk("R11 wrap fill");
            pop(1'b0);
            for (int k = 0; k < 12; k++) pop(1'b1);
            settle();
            wr_flags_chk("R11 wrap drain");
        end

        // R9 rewind and replay
        global_reset();
        for (int k = 0; k < 6; k++) push(8'(8'h40 + k), 1'b1);
        settle();
        for (int k = 0; k < 4; k++) pop(1'b1);
        settle();
        @(negedge rclk);
        rprst = 1; rce = 1; re = 1;
        @(negedge rclk);
        rprst = 0; rce = 0; re = 0;
        rd_idx = 0;
        chk("R9 rdata held on rewind", 32'(rdata), 32'(last_rd));
        rd_flags_chk("R9 rewind flags");
        settle();
        wr_flags_chk("R9 R8 producer after rewind");
        for (int k = 0; k < 6; k++) pop(1'b1);
        for (int k = 0; k < 2; k++) push(8'(8'h70 + k), 1'b1);
        settle();
        for (int k = 0; k < 3; k++) pop(1'b1);
        chk("R9 level after replay", 32'(level()), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule